// File: doc/BRIEF.md
# Configuration sequence controller

This block is the control state machine that takes a programmable device from power-up through loading its configuration, into an orderly start of user logic, and later through readback, power-down and reconfiguration. It waits out a fixed power-on interval and for the device reset to be released. It then samples the three mode pins once and shifts a serial configuration stream into a frame store. The stream is clocked either by a clock that the block generates itself (master) or by an external clock (slave).

Once the frame is complete, the block releases user logic in a fixed synchronous order. Each external control has a meaning that depends on the phase the block is in. The device reset restarts a load that is in progress, but after configuration it only clears user storage, and it does so asynchronously. A falling edge on the done line starts a fresh configuration. A rising edge on mode pin 0 streams the stored frame back out, inverted. Power-down quiets everything, keeps the frame, and replays the start order when it is lifted.

All asynchronous control inputs pass through two-flop synchronizers before any edge is detected. The only exception is the post-configuration storage clear, which acts directly.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After `pwr_rst` is released, no load starts (`cfg_clk_oe` stays 0 and no bit is captured) until `POR_CYCLES` clocks have elapsed. While `rst_n_pin` is held low, no load starts at all.
- R2: The mode pins are sampled once, when a load begins. Code 000 selects master serial: `cfg_clk_oe` is 1 and `cfg_clk_out` toggles every `CCLK_HALF` clocks. Any other code selects slave serial. Later changes on the mode pins do not alter the mode of a load in progress.
- R3: If `rst_n_pin` goes low during a load, the load is abandoned and user logic stays inactive. After release, a new load starts again from frame bit 0.
- R4: While configured, a low `rst_n_pin` drives `user_clr` high at once, without waiting for a clock. The loaded frame, `done_out` and `user_oe` are kept.
- R5: While configured, a falling edge on `done_in` deactivates user logic (`user_oe`=0, `user_clr`=1, `done_out`=0). It then starts a new load with a fresh sample of the mode pins.
- R6: While configured, a rising edge on `mode_pins[0]` starts a readback. `rb_data_n` shows the inverse of frame bit 0 and advances one bit on each rising edge of `cfg_clk_in`. After `FRAME_BITS` bits the block returns to normal operation. Outside readback, `rb_data_n` is 1.
- R7: While configured, a low `pwrdn_n` drives `user_oe`=0, `user_clr`=1, `done_out`=0 and `cfg_clk_oe`=0. When `pwrdn_n` returns high, the same start order as after a load is replayed, and the frame is unchanged.
- R8: Start order: `user_clr` is released exactly one clock after `user_oe` rises. Frame bit 0, the first bit shifted in, chooses where `done_out` rises. When it is 1, `done_out` rises one clock before `user_oe`. When it is 0, `done_out` rises one clock after `user_clr` is released.
- R9: In slave mode each frame bit is captured on a rising edge of `cfg_clk_in`, and `cfg_clk_oe` and `cfg_clk_out` stay 0.
- R10: While `pwr_rst` is high, `user_oe`=0, `user_clr`=1, `done_out`=0, `cfg_clk_oe`=0 and `rb_data_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_rst | input | 1 | Synchronous active-high power-applied reset |
| rst_n_pin | input | 1 | Device reset, active low, phase-dependent meaning |
| pwrdn_n | input | 1 | Power-down request, active low |
| done_in | input | 1 | Sensed level of the done/program line |
| mode_pins | input | 3 | Mode pins; bit 0 doubles as readback trigger |
| cfg_clk_in | input | 1 | External configuration clock (slave load, readback) |
| cfg_din | input | 1 | Serial configuration data |
| cfg_clk_out | output | 1 | Generated configuration clock in master mode |
| cfg_clk_oe | output | 1 | Enable for the generated configuration clock |
| user_oe | output | 1 | Output enable toward user logic |
| user_clr | output | 1 | Storage reset toward user logic |
| rb_data_n | output | 1 | Readback data, active low |
| done_out | output | 1 | Configuration done indication |

## Verification
The bench first loads a frame whose bit 0 selects the late done position, and later loads a second frame that selects the early one. It timestamps the rise of `user_oe`, the release of `user_clr` and the rise of `done_out` each time, so a design that swaps or merges those steps shows a wrong offset. It interrupts a slave load with reset after feeding deliberately wrong bits. Each frame is read back bit by bit, which exposes a design that keeps its bit counter across the restart, captures on the wrong clock edge or loses the frame across power-down and reset. It also flips the mode pins in the middle of a load, and probes `user_clr` within a fraction of a clock after reset falls, so that a design which re-samples the mode or synchronizes the post-configuration clear is caught.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_POR,    // power-on interval
        ST_WAIT,   // waiting for device reset release
        ST_MODE,   // sample mode pins
        ST_LOAD,   // shifting frame bits
        ST_START,  // ordered activation
        ST_RUN,    // configured, user logic active
        ST_RDBK,   // streaming frame back out
        ST_PDN     // powered down, frame kept
    } seq_state_e;

    typedef enum logic {
        LD_MASTER,
        LD_SLAVE
    } load_mode_e;

    // Synchronized view of the asynchronous pins
    typedef struct packed {
        logic [2:0] mode;
        logic       din;
        logic       cclk;
        logic       done;
        logic       pwrdn_n;
        logic       rst_n;
    } pin_bus_t;

    // Idle levels: reset, power-down and done released, everything else low
    localparam pin_bus_t PIN_IDLE = '{mode: 3'b000, din: 1'b0, cclk: 1'b0,
                                      done: 1'b1, pwrdn_n: 1'b1, rst_n: 1'b1};

    typedef struct packed {
        logic oe;
        logic clr;
        logic done;
    } user_ctl_t;

    localparam logic [2:0] MODE_MASTER_SER = 3'b000;
    localparam int         START_LAST_STEP = 2;

    function automatic load_mode_e decode_mode(input logic [2:0] pins);
        return (pins == MODE_MASTER_SER) ? LD_MASTER : LD_SLAVE;
    endfunction

    // Activation controls for one step of the start order
    function automatic user_ctl_t startup_ctl(input logic [1:0] step, input logic done_first);
        user_ctl_t c;
        if (done_first) begin
            c.done = 1'b1;
            c.oe   = (step >= 2'd1);
            c.clr  = (step <  2'd2);
        end else begin
            c.oe   = 1'b1;
            c.clr  = (step <  2'd1);
            c.done = (step >= 2'd2);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int               WIDTH = 1,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            stage2 <= INIT;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

endmodule

// File: rtl/cfg_clk_gen.sv
module cfg_clk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic cclk,
    output logic rise
);

    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          cclk_q;
    logic          last;

    assign last = (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt    <= '0;
            cclk_q <= 1'b0;
        end else if (last) begin
            cnt    <= '0;
            cclk_q <= ~cclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign cclk = cclk_q;
    assign rise = run && last && !cclk_q;

endmodule

// File: rtl/cfg_frame_store.sv
module cfg_frame_store #(
    parameter int BITS = 32,
    localparam int IW  = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_bit,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_bit,
    output logic          opt_bit
);

    logic [BITS-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_bit;
        end
    end

    assign rd_bit  = mem[rd_idx];
    assign opt_bit = mem[0];

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int POR_CYCLES = 16,
    parameter int FRAME_BITS = 32,
    parameter int CCLK_HALF  = 2
) (
    input  logic       clk,
    input  logic       pwr_rst,
    input  logic       rst_n_pin,
    input  logic       pwrdn_n,
    input  logic       done_in,
    input  logic [2:0] mode_pins,
    input  logic       cfg_clk_in,
    input  logic       cfg_din,
    output logic       cfg_clk_out,
    output logic       cfg_clk_oe,
    output logic       user_oe,
    output logic       user_clr,
    output logic       rb_data_n,
    output logic       done_out
);

    localparam int PW = $clog2(POR_CYCLES + 1);
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam int IW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

    // ---------------- pin synchronization and edges ----------------
    pin_bus_t raw_pins;
    pin_bus_t syn;
    logic     prev_m0, prev_done, prev_cclk;
    logic     m0_rise, done_fall, sclk_rise;

    assign raw_pins = '{mode: mode_pins, din: cfg_din, cclk: cfg_clk_in,
                        done: done_in, pwrdn_n: pwrdn_n, rst_n: rst_n_pin};

    cfg_sync #(
        .WIDTH ($bits(pin_bus_t)),
        .INIT  (PIN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (pwr_rst),
        .d   (raw_pins),
        .q   (syn)
    );

    always_ff @(posedge clk) begin
        if (pwr_rst) begin
            prev_m0   <= PIN_IDLE.mode[0];
            prev_done <= PIN_IDLE.done;
            prev_cclk <= PIN_IDLE.cclk;
        end else begin
            prev_m0   <= syn.mode[0];
            prev_done <= syn.done;
            prev_cclk <= syn.cclk;
        end
    end

    assign m0_rise   =  syn.mode[0] & ~prev_m0;
    assign done_fall = ~syn.done    &  prev_done;
    assign sclk_rise =  syn.cclk    & ~prev_cclk;

    // ---------------- sequencer state ----------------
    seq_state_e    state;
    load_mode_e    ld_mode;
    logic [PW-1:0] por_cnt;
    logic [BW-1:0] bit_cnt;
    logic [BW-1:0] rb_cnt;
    logic [1:0]    step;

    logic master_run, m_rise, bit_stb, wr_en;
    logic rd_bit, opt_bit;
    logic cclk_gen;

    assign master_run = (state == ST_LOAD) && (ld_mode == LD_MASTER);
    assign bit_stb    = (ld_mode == LD_MASTER) ? m_rise : sclk_rise;
    assign wr_en      = (state == ST_LOAD) && bit_stb && syn.rst_n;

    cfg_clk_gen #(
        .HALF (CCLK_HALF)
    ) u_cclk (
        .clk  (clk),
        .rst  (pwr_rst),
        .run  (master_run),
        .cclk (cclk_gen),
        .rise (m_rise)
    );

    cfg_frame_store #(
        .BITS (FRAME_BITS)
    ) u_store (
        .clk     (clk),
        .rst     (pwr_rst),
        .wr_en   (wr_en),
        .wr_idx  (bit_cnt[IW-1:0]),
        .wr_bit  (syn.din),
        .rd_idx  (rb_cnt[IW-1:0]),
        .rd_bit  (rd_bit),
        .opt_bit (opt_bit)
    );

    always_ff @(posedge clk) begin
        if (pwr_rst) begin
            state   <= ST_POR;
            ld_mode <= LD_SLAVE;
            por_cnt <= '0;
            bit_cnt <= '0;
            rb_cnt  <= '0;
            step    <= '0;
        end else begin
            unique case (state)
                ST_POR: begin
                    if (por_cnt != PW'(POR_CYCLES)) begin
                        por_cnt <= por_cnt + 1'b1;
                    end else if (syn.rst_n) begin
                        state <= ST_MODE;
                    end
                end
                ST_WAIT: begin
                    if (syn.rst_n) begin
                        state <= ST_MODE;
                    end
                end
                ST_MODE: begin
                    ld_mode <= decode_mode(syn.mode);
                    bit_cnt <= '0;
                    state   <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (!syn.rst_n) begin
                        state <= ST_WAIT;
                    end else if (bit_stb) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BW'(FRAME_BITS - 1)) begin
                            state <= ST_START;
                            step  <= '0;
                        end
                    end
                end
                ST_START: begin
                    if (!syn.rst_n) begin
                        state <= ST_WAIT;
                    end else if (step == 2'(START_LAST_STEP)) begin
                        state <= ST_RUN;
                    end else begin
                        step <= step + 2'd1;
                    end
                end
                ST_RUN: begin
                    if (!syn.pwrdn_n) begin
                        state <= ST_PDN;
                    end else if (done_fall) begin
                        state <= ST_WAIT;
                    end else if (m0_rise) begin
                        state  <= ST_RDBK;
                        rb_cnt <= '0;
                    end
                end
                ST_RDBK: begin
                    if (!syn.pwrdn_n) begin
                        state <= ST_PDN;
                    end else if (done_fall) begin
                        state <= ST_WAIT;
                    end else if (sclk_rise) begin
                        rb_cnt <= rb_cnt + 1'b1;
                        if (rb_cnt == BW'(FRAME_BITS - 1)) begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_PDN: begin
                    if (syn.pwrdn_n) begin
                        state <= ST_START;
                        step  <= '0;
                    end
                end
                default: state <= ST_POR;
            endcase
        end
    end

    // ---------------- user-side controls ----------------
    user_ctl_t ctl;
    logic      configured;

    always_comb begin
        unique case (state)
            ST_START:         ctl = startup_ctl(step, opt_bit);
            ST_RUN, ST_RDBK:  ctl = '{oe: 1'b1, clr: 1'b0, done: 1'b1};
            default:          ctl = '{oe: 1'b0, clr: 1'b1, done: 1'b0};
        endcase
    end

    assign configured = (state == ST_START) || (state == ST_RUN) || (state == ST_RDBK);

    assign user_oe     = ctl.oe;
    assign user_clr    = ctl.clr | (configured & ~rst_n_pin);
    assign done_out    = ctl.done;
    assign rb_data_n   = (state == ST_RDBK) ? ~rd_bit : 1'b1;
    assign cfg_clk_oe  = master_run;
    assign cfg_clk_out = cclk_gen;

endmodule

// File: rtl/cfg_seq_ctrl_chk.sv
module cfg_seq_ctrl_chk (
    input logic clk,
    input logic pwr_rst,
    input logic rst_n_pin,
    input logic cfg_clk_oe,
    input logic user_oe,
    input logic user_clr,
    input logic rb_data_n,
    input logic done_out
);

    AST_CLR_WHILE_OE_OFF: assert property (@(posedge clk) disable iff (pwr_rst)
        !user_oe |-> user_clr); // R8

    AST_CLR_FALLS_AFTER_OE: assert property (@(posedge clk) disable iff (pwr_rst)
        $fell(user_clr) |-> $past(user_oe)); // R8

    AST_CCLK_ONLY_IN_LOAD: assert property (@(posedge clk) disable iff (pwr_rst)
        cfg_clk_oe |-> (!done_out && !user_oe)); // R2

    AST_RB_IDLE_UNCONFIGURED: assert property (@(posedge clk) disable iff (pwr_rst)
        !done_out |-> rb_data_n); // R6

    AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (pwr_rst)
        (done_out && !rst_n_pin) |-> user_clr); // R4

endmodule

bind cfg_seq_ctrl cfg_seq_ctrl_chk u_chk (
    .clk        (clk),
    .pwr_rst    (pwr_rst),
    .rst_n_pin  (rst_n_pin),
    .cfg_clk_oe (cfg_clk_oe),
    .user_oe    (user_oe),
    .user_clr   (user_clr),
    .rb_data_n  (rb_data_n),
    .done_out   (done_out)
);

// File: tb/sim_cfg_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_seq_ctrl;

    localparam int POR = 16;
    localparam int FB  = 32;
    localparam int HLF = 2;

    localparam logic [FB-1:0] FRAME_A = 32'hA5C3_1E70; // bit0 = 0 -> done late
    localparam logic [FB-1:0] FRAME_B = 32'h3C96_0F5B; // bit0 = 1 -> done early

    logic       clk = 1'b0;
    logic       pwr_rst = 1'b1;
    logic       rst_n_pin = 1'b0;
    logic       pwrdn_n = 1'b1;
    logic       done_in = 1'b1;
    logic [2:0] mode_pins = 3'b000;
    logic       cfg_clk_in = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_clk_out, cfg_clk_oe, user_oe, user_clr, rb_data_n, done_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic exp_q[$];

    always #2 clk = ~clk;

    cfg_seq_ctrl #(
        .POR_CYCLES (POR),
        .FRAME_BITS (FB),
        .CCLK_HALF  (HLF)
    ) u0 (
        .clk         (clk),
        .pwr_rst     (pwr_rst),
        .rst_n_pin   (rst_n_pin),
        .pwrdn_n     (pwrdn_n),
        .done_in     (done_in),
        .mode_pins   (mode_pins),
        .cfg_clk_in  (cfg_clk_in),
        .cfg_din     (cfg_din),
        .cfg_clk_out (cfg_clk_out),
        .cfg_clk_oe  (cfg_clk_oe),
        .user_oe     (user_oe),
        .user_clr    (user_clr),
        .rb_data_n   (rb_data_n),
        .done_out    (done_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic check_idle(input string req);
        check(user_oe == 1'b0,    req, "user_oe",    int'(user_oe),    0);
        check(user_clr == 1'b1,   req, "user_clr",   int'(user_clr),   1);
        check(done_out == 1'b0,   req, "done_out",   int'(done_out),   0);
        check(cfg_clk_oe == 1'b0, req, "cfg_clk_oe", int'(cfg_clk_oe), 0);
    endtask

    // driver side of the scoreboard: expected readback items
    task automatic push_expected(input logic [FB-1:0] fr);
        for (int i = 0; i < FB; i++) exp_q.push_back(~fr[i]);
    endtask

    task automatic master_load(input logic [FB-1:0] fr);
        logic prev;
        logic rose;
        int   guard;
        prev = cfg_clk_out;
        for (int i = 0; i < FB; i++) begin
            cfg_din = fr[i];
            guard = 0;
            rose = 1'b0;
            while (!rose && guard < 100) begin
                @(negedge clk);
                rose = cfg_clk_out && !prev;
                prev = cfg_clk_out;
                guard++;
            end
        end
    endtask

    task automatic slave_bits(input logic [FB-1:0] fr, input int n);
        for (int i = 0; i < n; i++) begin
            cfg_din = fr[i];
            repeat (2) @(negedge clk);
            cfg_clk_in = 1'b1;
            repeat (3) @(negedge clk);
            check(cfg_clk_oe == 1'b0 && cfg_clk_out == 1'b0, "R9", "slave clk outputs",
                  int'({cfg_clk_oe, cfg_clk_out}), 0);
            cfg_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic watch_startup(input bit early, input int limit, input string req);
        int t_oe;
        int t_clr;
        int t_dn;
        t_oe = -1; t_clr = -1; t_dn = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (t_oe  < 0 && user_oe)   t_oe  = i;
            if (t_clr < 0 && !user_clr) t_clr = i;
            if (t_dn  < 0 && done_out)  t_dn  = i;
            if (t_oe >= 0 && t_clr >= 0 && t_dn >= 0) break;
        end
        check(t_oe >= 0, req, "user_oe rose", t_oe, 0);
        check(t_clr == t_oe + 1, req, "clr release vs oe", t_clr - t_oe, 1);
        if (early)
            check(t_dn == t_oe - 1, req, "done vs oe (early)", t_dn - t_oe, -1);
        else
            check(t_dn == t_clr + 1, req, "done vs clr (late)", t_dn - t_clr, 1);
    endtask

    // monitor side: pops expected items as readback bits appear
    task automatic readback(input string req);
        logic e;
        mode_pins[0] = 1'b0;
        repeat (4) @(negedge clk);
        mode_pins[0] = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < FB; i++) begin
            e = exp_q.pop_front();
            check(rb_data_n == e, req, $sformatf("readback bit %0d", i), int'(rb_data_n), int'(e));
            cfg_clk_in = 1'b1;
            repeat (3) @(negedge clk);
            cfg_clk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        check(rb_data_n == 1'b1, req, "rb idle after readback", int'(rb_data_n), 1);
        check(done_out == 1'b1, req, "done kept after readback", int'(done_out), 1);
    endtask

    initial begin : main
        int n;
        // R10: reset state
        repeat (3) @(negedge clk);
        check_idle("R10");
        check(rb_data_n == 1'b1, "R10", "rb_data_n", int'(rb_data_n), 1);
        pwr_rst = 1'b0;

        // R1: reset held beyond the power-on interval blocks the load
        repeat (POR + 10) @(negedge clk);
        check(cfg_clk_oe == 1'b0, "R1", "load while reset held", int'(cfg_clk_oe), 0);
        cfg_din = FRAME_A[0];
        rst_n_pin = 1'b1;
        n = 0;
        while (!cfg_clk_oe && n < 100) begin @(negedge clk); n++; end
        check(n >= 2 && n <= 8, "R1", "cycles from reset release to load", n, 4);

        // R2 master load, R8 late start order
        fork
            master_load(FRAME_A);
            watch_startup(1'b0, FB * 4 * HLF + 60, "R8");
            begin
                repeat (20) @(negedge clk);
                mode_pins = 3'b111;
                repeat (10) @(negedge clk);
                check(cfg_clk_oe == 1'b1, "R2", "mode held after pin change", int'(cfg_clk_oe), 1);
                mode_pins = 3'b000;
            end
        join
        repeat (4) @(negedge clk);
        check(done_out && user_oe && !user_clr, "R8", "configured outputs",
              int'({done_out, user_oe, user_clr}), 6);
        push_expected(FRAME_A);
        readback("R6");

        // R4: asynchronous storage clear after configuration
        @(negedge clk);
        rst_n_pin = 1'b0;
        #0.5;
        check(user_clr == 1'b1, "R4", "immediate clear", int'(user_clr), 1);
        repeat (6) @(negedge clk);
        check(done_out == 1'b1 && user_oe == 1'b1, "R4", "config kept during reset",
              int'({done_out, user_oe}), 3);
        rst_n_pin = 1'b1;
        repeat (4) @(negedge clk);
        check(user_clr == 1'b0, "R4", "clear released", int'(user_clr), 0);
        push_expected(FRAME_A);
        readback("R4");

        // R7: power-down and replay
        pwrdn_n = 1'b0;
        repeat (5) @(negedge clk);
        check_idle("R7");
        mode_pins = 3'b111;   // edge on pin 0 while powered down has no effect
        repeat (4) @(negedge clk);
        check(rb_data_n == 1'b1, "R7", "no readback during power-down", int'(rb_data_n), 1);
        fork
            pwrdn_n = 1'b1;
            watch_startup(1'b0, 40, "R7");
        join
        repeat (3) @(negedge clk);
        push_expected(FRAME_A);
        readback("R7");

        // R5: done line falling edge reconfigures (mode now slave)
        done_in = 1'b0;
        repeat (4) @(negedge clk);
        done_in = 1'b1;
        check(done_out == 1'b0 && user_oe == 1'b0 && user_clr == 1'b1, "R5",
              "user logic off after done fall", int'({done_out, user_oe, user_clr}), 1);
        repeat (4) @(negedge clk);
        check(cfg_clk_oe == 1'b0, "R5", "fresh mode sample is slave", int'(cfg_clk_oe), 0);

        // R3: reset interrupts a slave load with wrong bits
        slave_bits(~FRAME_B, 10);
        rst_n_pin = 1'b0;
        repeat (6) @(negedge clk);
        check(user_oe == 1'b0 && done_out == 1'b0, "R3", "inactive after abort",
              int'({user_oe, done_out}), 0);
        rst_n_pin = 1'b1;
        repeat (8) @(negedge clk);

        // R9 slave load, R8 early start order
        fork
            slave_bits(FRAME_B, FB);
            watch_startup(1'b1, FB * 8 + 60, "R8");
        join
        repeat (4) @(negedge clk);
        push_expected(FRAME_B);
        readback("R3");

        // R1: power cycle with reset released measures the power-on interval
        pwr_rst = 1'b1;
        mode_pins = 3'b000;
        repeat (3) @(negedge clk);
        check_idle("R10");
        pwr_rst = 1'b0;
        n = 0;
        while (!cfg_clk_oe && n < 200) begin @(negedge clk); n++; end
        check(n >= POR && n <= POR + 4, "R1", "power-on interval", n, POR + 2);

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule